// File: doc/BRIEF.md
# Output Line-Start Sync Pulse Generator

This block drives a sync pulse that tells a downstream scaler where each line of the output pixel stream begins. It runs on the output data clock and uses a one-cycle strobe that marks pixel 0 of every line. The pulse ends exactly as pixel 0 appears. Pixel 0 cannot be seen in advance, so the block counts pixels from each strobe. Using the programmed line length, it works out in which cycle of the current line the pulse has to begin.

The pulse width is given in pixel clocks by an 8-bit value. The width only moves the leading edge: a wider pulse starts earlier in the previous line, and its end stays on pixel 0. A polarity bit selects an active-high or active-low pulse. Line length, width and polarity are captured together on each strobe. Changes that arrive on any other cycle therefore cannot cut or stretch a pulse that is already running.

Top module: `line_sync_gen`

## Requirements
- R1: While rst_ni is low, and after reset until the first line_start_i strobe, sync_o is low (the reset polarity is active-high, so the idle level is 0) and no pulse is produced.
- R2: In the cycle where line_start_i is high (pixel 0), sync_o is at its inactive level, provided the strobe arrives no earlier than line length cycles after the previous one.
- R3: With line length L and effective width W captured at a strobe, sync_o is active for pixels L−W through L−1 of that line and is inactive for pixels 1 through L−W−1.
- R4: The polarity bit selects the pulse sense: 1 means active-high (inactive level 0) and 0 means active-low (inactive level 1). A newly captured polarity first shows at pixel 1, and pixel 0 keeps the previous line's inactive level.
- R5: A captured width of 0 produces no pulse, so sync_o stays at its inactive level for the whole line.
- R6: A width equal to or greater than L is clamped to L−1, and a line length of 0 gives an effective width of 0.
- R7: line_len_i, width_i and pol_i are sampled only in the strobe cycle. Changes to them on any other cycle have no effect on sync_o for the rest of that line.
- R8: If the next strobe comes later than L cycles after the last one, sync_o stays at its inactive level from pixel L onward until that strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output data clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | One-cycle strobe marking pixel 0 |
| line_len_i | input | 12 | Line length in pixels, captured at the strobe |
| width_i | input | 8 | Pulse width in pixel clocks, captured at the strobe |
| pol_i | input | 1 | 1 = active-high pulse, 0 = active-low pulse, captured at the strobe |
| sync_o | output | 1 | Registered line-start sync output |

## Verification
The strobe cycle does two jobs at once. It ends the running pulse at pixel 0, and it captures a new width, length and polarity for the line that follows. To test this, the bench changes the polarity and the width at the same strobe that ends a pulse. It then checks that pixel 0 shows the old inactive level, and that from pixel 1 on the idle level and pulse position follow the new settings. It also changes all three inputs in the middle of a line and checks that the rest of that line is unaffected.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  localparam int unsigned LEN_W = 12;
  localparam int unsigned WID_W = 8;
endpackage

// File: rtl/lsync_pix_cnt.sv
module lsync_pix_cnt #(
  parameter int unsigned LEN_W = lsync_pkg::LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  output logic [LEN_W-1:0] pix_o,
  output logic             seen_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [LEN_W-1:0] cnt_q;
  logic             seen_q;

  // pixel index of the current cycle
  assign pix_o  = line_start_i ? '0 : cnt_q;
  assign seen_o = seen_q | line_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (line_start_i) seen_q <= 1'b1;
      cnt_q <= (pix_o == CNT_MAX) ? CNT_MAX : pix_o + LEN_W'(1);
    end
  end

  // R8: a missing strobe parks the counter, never wraps into a new pulse
  a_r8_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R1: nothing counted as seen before the first strobe
  a_r1_seen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> seen_q);
endmodule

// File: rtl/lsync_cfg.sv
module lsync_cfg #(
  parameter int unsigned LEN_W = lsync_pkg::LEN_W,
  parameter int unsigned WID_W = lsync_pkg::WID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             pol_i,
  output logic [LEN_W-1:0] len_n_o,
  output logic [WID_W-1:0] wid_n_o,
  output logic             pol_n_o,
  output logic [WID_W-1:0] wid_o,
  output logic             pol_o
);
  logic [LEN_W-1:0] len_q;
  logic [WID_W-1:0] wid_q;
  logic             pol_q;
  logic [LEN_W-1:0] w_ext;
  logic [LEN_W-1:0] len_m1;
  logic [WID_W-1:0] w_clamp;

  assign w_ext  = LEN_W'(width_i);
  assign len_m1 = len_i - LEN_W'(1);

  always_comb begin
    if (len_i == '0)          w_clamp = '0;
    else if (w_ext >= len_i)  w_clamp = WID_W'(len_m1);
    else                      w_clamp = width_i;
  end

  // values in force for the cycle after this edge
  assign len_n_o = line_start_i ? len_i   : len_q;
  assign wid_n_o = line_start_i ? w_clamp : wid_q;
  assign pol_n_o = line_start_i ? pol_i   : pol_q;
  assign wid_o   = wid_q;
  assign pol_o   = pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      wid_q <= '0;
      pol_q <= 1'b1;
    end else if (line_start_i) begin
      len_q <= len_i;
      wid_q <= w_clamp;
      pol_q <= pol_i;
    end
  end

  a_r6_width_below_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_q == '0) || (LEN_W'(wid_q) < len_q));

  a_r7_hold_off_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_start_i |=> ($stable(wid_q) && $stable(len_q) && $stable(pol_q)));
endmodule

// File: rtl/lsync_window.sv
module lsync_window #(
  parameter int unsigned LEN_W = lsync_pkg::LEN_W,
  parameter int unsigned WID_W = lsync_pkg::WID_W
) (
  input  logic [LEN_W-1:0] pix_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [WID_W-1:0] wid_i,
  input  logic             seen_i,
  output logic             act_o
);
  logic [LEN_W:0] nxt;
  logic [LEN_W:0] start;
  logic [LEN_W:0] len_x;

  // decide for the following pixel so the output flop lands on time
  assign nxt   = {1'b0, pix_i} + (LEN_W+1)'(1);
  assign len_x = {1'b0, len_i};
  assign start = len_x - (LEN_W+1)'(wid_i);
  assign act_o = seen_i && (wid_i != '0) && (nxt >= start) && (nxt < len_x);
endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen #(
  parameter int unsigned LEN_W = lsync_pkg::LEN_W,
  parameter int unsigned WID_W = lsync_pkg::WID_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_start_i,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             pol_i,
  output logic             sync_o
);
  logic [LEN_W-1:0] pix;
  logic             seen_n;
  logic [LEN_W-1:0] len_n;
  logic [WID_W-1:0] wid_n;
  logic             pol_n;
  logic [WID_W-1:0] wid_q;
  logic             pol_q;
  logic             act_n;
  logic             act_q;
  logic             sync_q;
  logic [WID_W:0]   run_q;

  lsync_pix_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .pix_o(pix), .seen_o(seen_n)
  );

  lsync_cfg #(.LEN_W(LEN_W), .WID_W(WID_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_start_i(line_start_i),
    .len_i(line_len_i), .width_i(width_i), .pol_i(pol_i),
    .len_n_o(len_n), .wid_n_o(wid_n), .pol_n_o(pol_n),
    .wid_o(wid_q), .pol_o(pol_q)
  );

  lsync_window #(.LEN_W(LEN_W), .WID_W(WID_W)) u_win (
    .pix_i(pix), .len_i(len_n), .wid_i(wid_n), .seen_i(seen_n), .act_o(act_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      sync_q <= act_n ? pol_n : ~pol_n;
    end
  end

  assign sync_o = sync_q;

  // length of the pulse just ended, for checking only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= '0;
    else if (act_q) run_q <= run_q + (WID_W+1)'(1);
    else            run_q <= '0;
  end

  // R2: assumes strobes no closer than the line length
  a_r2_idle_at_pixel0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |-> !act_q);

  a_r3_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> (run_q == (WID_W+1)'(wid_q)));

  a_r4_level_matches_pol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (sync_o == pol_q));

  a_r5_zero_width_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_q == '0 && !line_start_i) |=> !act_q);
endmodule

// File: tb/line_sync_gen_tb.sv
`timescale 1ns/1ps
module line_sync_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ls = 1'b0;
  logic [11:0] len = '0;
  logic [7:0]  wid = '0;
  logic        pol = 1'b1;
  logic        sync;

  int n_chk = 0;
  int n_bad = 0;
  bit prev_pol = 1'b1;

  always #4 clk = ~clk;

  line_sync_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls),
    .line_len_i(len), .width_i(wid), .pol_i(pol), .sync_o(sync)
  );

  // stimulus table: line length, width, polarity, requirement exercised
  localparam int NV = 12;
  localparam int VL[NV] = '{16, 16, 20, 10, 12, 12, 30,  8, 100, 5, 16, 3};
  localparam int VW[NV] = '{ 4,  1,  8,  0, 12, 200, 255, 7, 50,  3, 15, 2};
  localparam int VP[NV] = '{ 1,  1,  0,  1,  1,  0,  1,  0,  1,  1,  0, 1};
  localparam int VT[NV] = '{ 3,  3,  4,  5,  6,  6,  6,  4,  3,  3,  4, 3};

  function automatic string tag(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit exp, int t, int p);
    n_chk++;
    if (sync !== exp) begin
      n_bad++;
      $display("FAIL %s pixel %0d: sync_o=%b expected %b", tag(t), p, sync, exp);
    end
  endtask

  // one line; optional mid-line change of all config inputs (R7)
  task automatic run_line(int L, int w, bit p, int t, bit mid);
    int we;
    bit exp;
    we = (L == 0) ? 0 : ((w >= L) ? L - 1 : w);
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(!prev_pol, 2, i);               // R2: inactive with old polarity
      end else begin
        exp = (we > 0 && i >= L - we) ? p : !p;
        chk(exp, mid ? 7 : t, i);
      end
      ls = (i == 0);
      if (i == 0) begin
        len = 12'(L); wid = 8'(w); pol = p;
      end else if (mid && i == 2) begin
        len = 12'(L / 2); wid = 8'd1; pol = !p;
      end
    end
    prev_pol = p;
  endtask

  task automatic idle_chk(int n, int t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!prev_pol, t, i);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and no pulse before the first strobe
    repeat (3) @(negedge clk);
    chk(1'b0, 1, -1);
    rst_n = 1'b1;
    len = 12'd4; wid = 8'd3; pol = 1'b1;
    idle_chk(8, 1);

    for (int k = 0; k < NV; k++)
      run_line(VL[k], VW[k], VP[k] != 0, VT[k], 1'b0);

    // R7: mid-line changes ignored, then a normal line
    run_line(20, 5, 1'b1, 7, 1'b1);
    run_line(20, 5, 1'b1, 3, 1'b0);
    // R4: polarity flip and width change at the strobe that ends a pulse
    run_line(20, 9, 1'b0, 4, 1'b0);
    run_line(20, 2, 1'b1, 4, 1'b0);

    // R8: late strobe, output idles past pixel L-1
    run_line(12, 4, 1'b0, 3, 1'b0);
    idle_chk(6, 8);
    run_line(12, 4, 1'b0, 3, 1'b0);

    // R1: asynchronous reset in the middle of an active-high pulse
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      ls = (i == 0);
      if (i == 0) begin len = 12'd16; wid = 8'd8; pol = 1'b1; end
    end
    @(negedge clk);
    chk(1'b1, 3, 13);
    rst_n = 1'b0;
    #1;
    chk(1'b0, 1, -1);
    @(negedge clk);
    rst_n = 1'b1;
    prev_pol = 1'b1;
    idle_chk(20, 1);
    run_line(6, 2, 1'b1, 3, 1'b0);
    idle_chk(1, 2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule